// File: doc/BRIEF.md
# SIMD Shift-Right-Accumulate Lane Unit

This block is a packed-vector datapath for an unsigned shift-right-and-accumulate operation. It takes a 32-bit instruction word, a 128-bit source vector and a 128-bit accumulator vector. From the instruction it decodes the lane size (8, 16, 32 or 64 bits), the shift amount, the vector width and the two register numbers. Each source lane is shifted right with zero fill, optionally rounded, and then added to the matching accumulator lane. Every sum wraps inside its own lane, and the block produces no flags.

The surrounding pipeline supplies the operands read from its register file and writes `res_data` back to the register named by `res_rd`. Handshakes are valid/ready on both sides. An accepted instruction gives its result one cycle later. The block flags an instruction it cannot execute instead of computing it.

Top module: `vsra_lane_unit`

## Requirements
- R1: Each source lane is treated as unsigned and shifted right, with the vacated upper bits filled with zeros. When instruction bit 13 is 0, the shifted-out bits are discarded.
- R2: When instruction bit 12 is 1, the shifted lane is added to the accumulator lane of the same position. The sum is truncated to the lane width, so no carry crosses a lane boundary.
- R3: When instruction bit 12 is 0, zero replaces the accumulator, and each result lane equals its shifted source lane.
- R4: When instruction bit 13 is 1, the value 2^(shift-1) is added to the lane in a (lane width + 1)-bit sum before the shift. A shift equal to the lane width then gives 0 or 1.
- R5: The lane size is set by the highest set bit of immh (bits 22:19): bit 3 gives 64, bit 2 gives 32, bit 1 gives 16 and bit 0 gives 8. The shift equals 2 × lane size − {immh, immb}, where immb is bits 18:16.
- R6: In the vector form (bit 31 = 0, bit 29 = 1, bits 28:23 = 011110), bit 30 = 1 processes all 128 bits. Bit 30 = 0 processes only the low 64 bits and returns zero in bits 127:64.
- R7: The scalar form (bits 31:29 = 011, bits 28:23 = 111110) processes one 64-bit lane in bits 63:0 and returns zero in bits 127:64. It requires immh bit 3 to be set.
- R8: An instruction is flagged with `res_illegal` = 1 and `res_data` left unchanged in any of these cases: the fixed bits (15:14 = 00, 11:10 = 01) do not match, no form matches, immh is zero, the vector form has immh bit 3 set with bit 30 = 0, or the scalar form has immh bit 3 clear.
- R9: An instruction accepted while `in_valid` and `in_ready` are both high appears with `out_valid` after one clock edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_ready` is low, `out_valid` and the outputs hold steady.
- R10: `res_rd` and `res_rn` carry instruction bits 4:0 and 9:5 of the accepted instruction.
- R11: After reset, `out_valid`, `res_illegal` and `res_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Block can accept an instruction |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector |
| acc_vec | input | 128 | Accumulator vector |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| res_data | output | 128 | Result vector |
| res_illegal | output | 1 | Instruction was rejected |
| res_rd | output | 5 | Destination register number |
| res_rn | output | 5 | Source register number |

## Verification
The bench runs every immh:immb code, so every lane size and every shift amount, under all four combinations of rounding and accumulate and under both vector widths. Three operand patterns are used. With all-ones source and accumulator, each lane's sum wraps, which shows whether carries stay inside a lane. With a lone lane MSB in the source, the zero fill is exposed, along with the rounding increment at full-width shifts. A mixed pattern catches swapped or misaligned lanes. Separate cases cover the illegal encodings, the scalar form, register-number passthrough and a stalled output.

// File: rtl/vsra_lane_unit.sv
module vsra_lane_unit #(
  parameter int VW = 128,
  parameter int HW = VW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   insn,
  input  logic [VW-1:0] src_vec,
  input  logic [VW-1:0] acc_vec,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] res_data,
  output logic          res_illegal,
  output logic [4:0]    res_rd,
  output logic [4:0]    res_rn
);

  function automatic logic [63:0] lane_op(input logic [63:0] x, input logic [63:0] a,
                                           input logic [7:0] sh, input logic rnd,
                                           input logic use_acc, input logic [7:0] esz);
    logic [63:0] m;
    logic [64:0] t;
    logic [64:0] y;
    m = (esz == 8'd64) ? '1 : ((64'd1 << esz) - 64'd1);
    t = {1'b0, x & m} + (rnd ? (65'd1 << (sh - 8'd1)) : 65'd0);
    y = t >> sh;
    return (y[63:0] + (use_acc ? (a & m) : 64'd0)) & m;
  endfunction

  wire [3:0] immh    = insn[22:19];
  wire [6:0] code    = {insn[22:19], insn[18:16]};
  wire       wide    = insn[30];
  wire       rnd     = insn[13];
  wire       use_acc = insn[12];

  wire fixed_ok = insn[15:14] == 2'b00 && insn[11:10] == 2'b01 && insn[29];
  wire vec_form = !insn[31] && insn[28:23] == 6'b011110;
  wire scl_form = insn[31:30] == 2'b01 && insn[28:23] == 6'b111110;
  wire bad = !(fixed_ok && ((vec_form && immh != 4'd0 && !(immh[3] && !wide)) ||
                            (scl_form && immh[3])));
  wire half = scl_form || !wide;

  wire [7:0] esz = immh[3] ? 8'd64 : immh[2] ? 8'd32 : immh[1] ? 8'd16 : 8'd8;
  wire [7:0] sh  = (esz << 1) - {1'b0, code};

  logic [VW-1:0] r8, r16, r32, r64, sel;

  for (genvar g = 0; g < VW / 8; g++) begin : g_l8
    logic [63:0] o;
    assign o = lane_op({56'd0, src_vec[g*8 +: 8]}, {56'd0, acc_vec[g*8 +: 8]}, sh, rnd, use_acc, 8'd8);
    assign r8[g*8 +: 8] = o[7:0];
  end
  for (genvar g = 0; g < VW / 16; g++) begin : g_l16
    logic [63:0] o;
    assign o = lane_op({48'd0, src_vec[g*16 +: 16]}, {48'd0, acc_vec[g*16 +: 16]}, sh, rnd, use_acc, 8'd16);
    assign r16[g*16 +: 16] = o[15:0];
  end
  for (genvar g = 0; g < VW / 32; g++) begin : g_l32
    logic [63:0] o;
    assign o = lane_op({32'd0, src_vec[g*32 +: 32]}, {32'd0, acc_vec[g*32 +: 32]}, sh, rnd, use_acc, 8'd32);
    assign r32[g*32 +: 32] = o[31:0];
  end
  for (genvar g = 0; g < VW / 64; g++) begin : g_l64
    assign r64[g*64 +: 64] = lane_op(src_vec[g*64 +: 64], acc_vec[g*64 +: 64], sh, rnd, use_acc, 8'd64);
  end

  always_comb begin
    case (esz)
      8'd8:    sel = r8;
      8'd16:   sel = r16;
      8'd32:   sel = r32;
      default: sel = r64;
    endcase
    if (half) sel[VW-1:HW] = '0;
  end

  assign in_ready = !out_valid || out_ready;
  wire take = in_valid && in_ready;
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_data    <= '0;
      res_rd      <= '0;
      res_rn      <= '0;
      half_q      <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      res_illegal <= bad;
      res_rd      <= insn[4:0];
      res_rn      <= insn[9:5];
      if (!bad) begin
        res_data <= sel;
        half_q   <= half;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_data) && $stable(res_illegal)));
  // R9
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R8
  reject_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad) |=> (res_illegal && $stable(res_data)));
  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !res_illegal && half_q) |-> res_data[VW-1:HW] == '0);
  // R10
  regnum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (res_rd == $past(insn[4:0]) && res_rn == $past(insn[9:5])));

endmodule

// File: tb/vsra_lane_unit_tb_top.sv
`timescale 1ns/1ps
module vsra_lane_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [31:0] insn = 0;
  logic [127:0] src_vec = 0, acc_vec = 0;
  logic in_ready, out_valid, res_illegal;
  logic [127:0] res_data;
  logic [4:0] res_rd, res_rn;
  int checks = 0, fails = 0;
  logic [127:0] last = 0;

  always #4 clk = ~clk;

  vsra_lane_unit dut_i (.clk, .rst_n, .in_valid, .in_ready, .insn, .src_vec, .acc_vec,
                        .out_valid, .out_ready, .res_data, .res_illegal, .res_rd, .res_rn);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_w(bit q, bit rnd, bit acc, logic [6:0] code, logic [4:0] rn, logic [4:0] rd);
    return {1'b0, q, 1'b1, 6'b011110, code, 2'b00, rnd, acc, 2'b01, rn, rd};
  endfunction
  function automatic logic [31:0] scl_w(bit rnd, bit acc, logic [6:0] code);
    return {2'b01, 1'b1, 6'b111110, code, 2'b00, rnd, acc, 2'b01, 5'd3, 5'd7};
  endfunction

  function automatic logic [128:0] model(logic [31:0] w, logic [127:0] s, logic [127:0] a);
    logic [3:0] immh = w[22:19];
    int code = int'(w[22:16]);
    bit scl = (w[31:29] == 3'b011) && w[28:23] == 6'b111110;
    bit vec = !w[31] && w[29] && w[28:23] == 6'b011110;
    bit ok = w[15:14] == 0 && w[11:10] == 2'b01 &&
             ((vec && immh != 0 && !(immh[3] && !w[30])) || (scl && immh[3]));
    int es = immh[3] ? 64 : immh[2] ? 32 : immh[1] ? 16 : 8;
    int sh = 2 * es - code;
    int span = (scl || !w[30]) ? 64 : 128;
    logic [128:0] r = 0;
    if (!ok) return {1'b1, last};
    for (int e = 0; e < span / es; e++) begin
      logic [128:0] m = ({129'd0, 1'b1} << es) - 1;
      logic [128:0] x = ({1'b0, s} >> (e * es)) & m;
      logic [128:0] y = ({1'b0, a} >> (e * es)) & m;
      logic [128:0] t = x + (w[13] ? ({129'd0, 1'b1} << (sh - 1)) : 0);
      t = (t >> sh) + (w[12] ? y : 0);
      r |= (t & m) << (e * es);
    end
    return {1'b0, r};
  endfunction

  task automatic run(logic [31:0] w, logic [127:0] s, logic [127:0] a, string tag);
    logic [128:0] e = model(w, s, a);
    @(negedge clk);
    insn = w; src_vec = s; acc_vec = a; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_valid === 1'b1, {tag, " R9 valid"}, {127'd0, out_valid}, 128'd1);
    check(res_illegal === e[128], {tag, " R8 illegal"}, {127'd0, res_illegal}, {127'd0, e[128]});
    check(res_data === e[127:0], tag, res_data, e[127:0]);
    last = res_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] pa [3];
    logic [127:0] pb [3];
    pa[0] = '1;                           pb[0] = '1;
    pa[1] = {16{8'h80}};                  pb[1] = {8{16'h7fff}};
    pa[2] = 128'hdeadbeef_0123abcd_f00dcafe_89ab5432; pb[2] = 128'h13579bdf_fedcba98_a5a55a5a_c3c33c3c;
    repeat (3) @(negedge clk);
    // R11
    check(out_valid === 0 && res_illegal === 0 && res_data === 0, "R11 reset", res_data, 0);
    rst_n = 1;
    // R1 R2 R3 R4 R5 R6 sweep; immh bit3 with q=0 covers R8
    for (int q = 0; q < 2; q++)
      for (int m = 0; m < 4; m++)
        for (int c = 8; c < 128; c++)
          for (int p = 0; p < 3; p++)
            run(vec_w(q[0], m[1], m[0], c[6:0], 5'd1, 5'd2), pa[p], pb[p], "R1/R2/R3/R4/R5/R6 sweep");
    // R7 scalar
    for (int c = 64; c < 128; c++)
      run(scl_w(c[0], c[1], c[6:0]), pa[2], pb[2], "R7 scalar");
    run(scl_w(0, 1, 7'd40), pa[0], pb[0], "R7 scalar needs 64-bit lane");
    // R8 illegal encodings
    run(vec_w(1, 0, 1, 7'd5, 5'd1, 5'd2), pa[1], pb[1], "R8 immh zero");
    run(vec_w(1, 0, 1, 7'd20, 5'd1, 5'd2) ^ 32'h0000_4000, pa[1], pb[1], "R8 fixed bit 14");
    run(vec_w(1, 0, 1, 7'd20, 5'd1, 5'd2) ^ 32'h0000_0400, pa[1], pb[1], "R8 fixed bit 10");
    run(vec_w(1, 0, 1, 7'd20, 5'd1, 5'd2) ^ 32'h0080_0000, pa[1], pb[1], "R8 form bits");
    // R10
    @(negedge clk);
    insn = vec_w(1, 0, 1, 7'd20, 5'd17, 5'd29); src_vec = pa[2]; acc_vec = pb[2]; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(res_rd === 5'd29, "R10 rd", {123'd0, res_rd}, 29);
    check(res_rn === 5'd17, "R10 rn", {123'd0, res_rn}, 17);
    // R9 stall
    out_ready = 0;
    @(negedge clk);
    insn = vec_w(1, 1, 1, 7'd9, 5'd1, 5'd2); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    last = res_data;
    check(in_ready === 0, "R9 not ready while stalled", {127'd0, in_ready}, 0);
    repeat (3) @(negedge clk);
    check(out_valid === 1 && res_data === last, "R9 hold", res_data, last);
    out_ready = 1;
    @(negedge clk);
    check(out_valid === 0 && in_ready === 1, "R9 drain", {127'd0, out_valid}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule